// File: doc/BRIEF.md
# Self-Correcting Clock Domain Disable Register

This block is one 32-bit control register. Each of nine bits turns one clock domain off. A 1 disables the domain and a 0 leaves it running. The bits sit at fixed positions in the word, and their outputs go straight to gating logic elsewhere on the chip. Software can read the register in any mode. A write has effect only when the bus marks the access as privileged. A wakeup input returns the whole register to its reset value, so that every domain runs again.

Each bit that software sees is held inside the block as a 4-bit key. The key for 0 is `1010` and the key for 1 is `0101`. The block decodes each key to whichever code it is nearest, so one upset storage bit never changes what the register shows. A key that is not an exact code raises an error pulse toward the system error collector, and on the next clock the key is rewritten with its corrected code. A sticky flag records that some error has happened until it is cleared. A flip input lets a test toggle any single key bit, so that upsets can be injected at the ports.

Top module: `clkoff_keyreg`

## Requirements
- R1: After reset, `dom_off_o` is all 0. A read of the register returns 0, and `err_pulse_o` and `err_sticky_o` are 0.
- R2: A write with `bus_sel`, `bus_wr` and `bus_priv` high at byte address 0x03C stores the word at the next clock edge. `dom_off_o[k]` then equals register bit P(k), where P = 0,1,2,3,4,5,6,8,11 for k = 0..8. A value of 1 means the domain is disabled.
- R3: A write with `bus_priv` low changes neither the register nor `dom_off_o`. A read returns the register contents whether `bus_priv` is high or low.
- R4: A write to any other address, or with `bus_sel` low, is ignored. `bus_rdata` is 0 unless `bus_sel` is high and the address is 0x03C.
- R5: The reserved bits (all bits other than the nine above) store a privileged write and read back the value written.
- R6: When `wake_i` is high at a clock edge, the whole register returns to 0 at that edge. This wins over a write in the same cycle.
- R7: Bit j of `flip_i[4k+3:4k]` high at a clock edge inverts bit j of domain k's key. After one such flip, `dom_off_o` and `bus_rdata` are unchanged.
- R8: In the cycle after a key is corrupted, `err_pulse_o` is high. At the following edge the key is rewritten with the nearest code, and the pulse drops.
- R9: A key with exactly two bits flipped decodes to 0 (domain enabled), and the scrub rewrites it as the code for 0.
- R10: `err_sticky_o` goes high at the edge after `err_pulse_o` is high and stays high until `err_clr_i` is sampled while no error is present. When a new error and the clear fall in the same cycle, the error wins.
- R11: A privileged write to a key that holds an error replaces the key with a fresh code, and no error remains after that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Bus access valid |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_priv | input | 1 | Access is privileged |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| wake_i | input | 1 | Wakeup: return all bits to 0 |
| flip_i | input | 36 | Fault injection, one bit per key bit |
| err_clr_i | input | 1 | Clear the sticky error flag |
| dom_off_o | output | 9 | Per-domain disable, 1 = off |
| err_pulse_o | output | 1 | A key is not an exact code |
| err_sticky_o | output | 1 | An error has been seen since the last clear |

## Verification
A key that holds the wrong value shows up as the wrong level on one line of `dom_off_o`, and also in the read word, in the same cycle the key is stored. A key that is damaged but still decodes correctly shows up only on `err_pulse_o`, in the cycle after the damaging edge. If the scrub is missing, the pulse stays high into a second cycle, and that is the tell-tale. Because the reference model is compared on every clock, any of these faults is caught within one cycle of the edge that causes it.

// File: rtl/clkoff_pkg.sv
package clkoff_pkg;

   // Control signals of one bus access
   typedef struct packed {
      logic sel;
      logic wr;
      logic priv;
   } bus_ctl_t;

   // Number of set bits in a mask
   function automatic int unsigned mask_ones(input logic [63:0] m);
      int unsigned n;
      n = 0;
      for (int i = 0; i < 64; i++) begin
         if (m[i]) n++;
      end
      return n;
   endfunction

   // Number of set bits strictly below position idx
   function automatic int unsigned ones_below(input logic [63:0] m, input int unsigned idx);
      int unsigned n;
      n = 0;
      for (int i = 0; i < 64; i++) begin
         if (m[i] && (i < int'(idx))) n++;
      end
      return n;
   endfunction

endpackage

// File: rtl/clkoff_bus_dec.sv
module clkoff_bus_dec #(
   parameter int unsigned ADDR_W = 12,
   parameter logic [ADDR_W-1:0] OFFSET = 12'h03C
) (
   input  clkoff_pkg::bus_ctl_t ctl,
   input  logic [ADDR_W-1:0]    addr,
   output logic                 wr_ok,
   output logic                 rd_hit
);
   logic at_reg;

   generate
      if (ADDR_W < 2) begin : g_bad_addr
         $error("clkoff_bus_dec: ADDR_W must be at least 2");
      end
   endgenerate

   always_comb begin
      at_reg = (addr == OFFSET);
      rd_hit = ctl.sel && at_reg;
      wr_ok  = ctl.sel && ctl.wr && ctl.priv && at_reg;
   end
endmodule

// File: rtl/clkoff_key_cell.sv
module clkoff_key_cell #(
   parameter int unsigned KEY_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wake,
   input  logic             wr_en,
   input  logic             wr_bit,
   input  logic [KEY_W-1:0] flip,
   output logic             bit_o,
   output logic             err_o
);
   function automatic logic [KEY_W-1:0] make_one();
      logic [KEY_W-1:0] r;
      for (int j = 0; j < KEY_W; j++) r[j] = ((j % 2) == 0);
      return r;
   endfunction

   localparam logic [KEY_W-1:0] CODE_ONE  = make_one();
   localparam logic [KEY_W-1:0] CODE_ZERO = ~CODE_ONE;
   localparam int unsigned HALF = KEY_W / 2;

   generate
      if ((KEY_W < 4) || ((KEY_W % 2) != 0)) begin : g_bad_key
         $error("clkoff_key_cell: KEY_W must be even and at least 4");
      end
   endgenerate

   logic [KEY_W-1:0] key_q;
   logic [KEY_W-1:0] key_nxt;
   int unsigned      agree;

   always_comb begin
      agree = 0;
      for (int j = 0; j < KEY_W; j++) begin
         if (key_q[j] == CODE_ONE[j]) agree++;
      end
      // a tie resolves toward the code for 0
      bit_o = (agree > HALF);
      err_o = (key_q != CODE_ONE) && (key_q != CODE_ZERO);
   end

   always_comb begin
      if (wake)       key_nxt = CODE_ZERO;
      else if (wr_en) key_nxt = wr_bit ? CODE_ONE : CODE_ZERO;
      else if (err_o) key_nxt = bit_o ? CODE_ONE : CODE_ZERO;
      else            key_nxt = key_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) key_q <= CODE_ZERO;
      else        key_q <= key_nxt ^ flip;
   end

   // R8
   scrub_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (err_o && !wake && !wr_en && (flip == '0)) |=> !err_o);

   // R7
   scrub_keeps_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (err_o && !wake && !wr_en && (flip == '0)) |=> $stable(bit_o));

   // R11
   write_fresh_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wake && (flip == '0)) |=> (!err_o && (bit_o == $past(wr_bit))));
endmodule

// File: rtl/clkoff_err_agg.sv
module clkoff_err_agg #(
   parameter int unsigned N = 9
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] err_vec,
   input  logic         clr,
   output logic         pulse_o,
   output logic         sticky_o
);
   generate
      if (N < 1) begin : g_bad_n
         $error("clkoff_err_agg: N must be at least 1");
      end
   endgenerate

   assign pulse_o = |err_vec;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       sticky_o <= 1'b0;
      else if (pulse_o) sticky_o <= 1'b1;
      else if (clr)     sticky_o <= 1'b0;
   end

   // R10
   sticky_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pulse_o |=> sticky_o);

   // R10
   sticky_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !pulse_o) |=> !sticky_o);
endmodule

// File: rtl/clkoff_keyreg.sv
module clkoff_keyreg #(
   parameter int unsigned        DATA_W     = 32,
   parameter int unsigned        ADDR_W     = 12,
   parameter logic [ADDR_W-1:0]  REG_OFFSET = 12'h03C,
   parameter logic [DATA_W-1:0]  FUNC_MASK  = 32'h0000_097F,
   parameter int unsigned        KEY_W      = 4,
   parameter bit                 RSVD_KEEP  = 1'b1,
   localparam int unsigned       NDOM       = clkoff_pkg::mask_ones(64'(FUNC_MASK)),
   localparam int unsigned       FLIP_W     = NDOM * KEY_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic              bus_priv,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              wake_i,
   input  logic [FLIP_W-1:0] flip_i,
   input  logic              err_clr_i,
   output logic [NDOM-1:0]   dom_off_o,
   output logic              err_pulse_o,
   output logic              err_sticky_o
);
   generate
      if ((DATA_W < 1) || (DATA_W > 64)) begin : g_bad_width
         $error("clkoff_keyreg: DATA_W must lie in 1..64");
      end
      if (NDOM < 1) begin : g_bad_mask
         $error("clkoff_keyreg: FUNC_MASK must select at least one bit");
      end
   endgenerate

   clkoff_pkg::bus_ctl_t ctl;
   logic                 wr_ok;
   logic                 rd_hit;
   logic [NDOM-1:0]      key_err;
   logic [DATA_W-1:0]    func_rd;
   logic [DATA_W-1:0]    rsv_rd;

   assign ctl.sel  = bus_sel;
   assign ctl.wr   = bus_wr;
   assign ctl.priv = bus_priv;

   clkoff_bus_dec #(
      .ADDR_W (ADDR_W),
      .OFFSET (REG_OFFSET)
   ) u_dec (
      .ctl    (ctl),
      .addr   (bus_addr),
      .wr_ok  (wr_ok),
      .rd_hit (rd_hit)
   );

   generate
      for (genvar b = 0; b < DATA_W; b++) begin : g_bit
         if (FUNC_MASK[b]) begin : g_key
            localparam int unsigned K = clkoff_pkg::ones_below(64'(FUNC_MASK), b);
            clkoff_key_cell #(
               .KEY_W (KEY_W)
            ) u_cell (
               .clk    (clk),
               .rst_n  (rst_n),
               .wake   (wake_i),
               .wr_en  (wr_ok),
               .wr_bit (bus_wdata[b]),
               .flip   (flip_i[K*KEY_W +: KEY_W]),
               .bit_o  (dom_off_o[K]),
               .err_o  (key_err[K])
            );
            assign func_rd[b] = dom_off_o[K];
         end else begin : g_plain
            assign func_rd[b] = 1'b0;
         end
      end

      if (RSVD_KEEP) begin : g_rsv_keep
         logic [DATA_W-1:0] rsv_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      rsv_q <= '0;
            else if (wake_i) rsv_q <= '0;
            else if (wr_ok)  rsv_q <= bus_wdata & ~FUNC_MASK;
         end
         assign rsv_rd = rsv_q;
      end else begin : g_rsv_zero
         assign rsv_rd = '0;
      end
   endgenerate

   assign bus_rdata = rd_hit ? (func_rd | rsv_rd) : '0;

   clkoff_err_agg #(
      .N (NDOM)
   ) u_err (
      .clk      (clk),
      .rst_n    (rst_n),
      .err_vec  (key_err),
      .clr      (err_clr_i),
      .pulse_o  (err_pulse_o),
      .sticky_o (err_sticky_o)
   );

   // R3
   user_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && bus_wr && !bus_priv && !wake_i && (flip_i == '0)) |=> $stable(dom_off_o));

   // R6
   wake_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wake_i && (flip_i == '0)) |=> ((dom_off_o == '0) && !err_pulse_o));

   // R4
   idle_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_sel |-> (bus_rdata == '0));
endmodule

// File: tb/clkoff_keyreg_tb.sv
module clkoff_keyreg_tb_top;
   localparam int ND = 9;
   localparam int KW = 4;
   localparam logic [11:0] OFF = 12'h03C;
   localparam int POS [ND] = '{0, 1, 2, 3, 4, 5, 6, 8, 11};

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0, bus_wr = 1'b0, bus_priv = 1'b0;
   logic [11:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        wake_i = 1'b0;
   logic [35:0] flip_i = '0;
   logic        err_clr_i = 1'b0;
   logic [8:0]  dom_off_o;
   logic        err_pulse_o, err_sticky_o;

   int total = 0;
   int bad = 0;
   bit finished = 0;
   string cur_req = "R1";

   // behavioural model
   bit          m_val [ND];
   logic [3:0]  m_msk [ND];
   logic [31:0] m_rsv;
   bit          m_sticky;
   logic [31:0] func_m;

   always #2 clk = ~clk;

   clkoff_keyreg dut_i (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_priv(bus_priv), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .wake_i(wake_i), .flip_i(flip_i),
      .err_clr_i(err_clr_i), .dom_off_o(dom_off_o),
      .err_pulse_o(err_pulse_o), .err_sticky_o(err_sticky_o));

   function automatic bit seen(int k);
      int n = $countones(m_msk[k]);
      if (n <= 1) return m_val[k];
      if (n == 2) return 1'b0;
      return ~m_val[k];
   endfunction

   function automatic bit any_err();
      for (int k = 0; k < ND; k++) if (m_msk[k] != 4'b0) return 1'b1;
      return 1'b0;
   endfunction

   task automatic check(string what, logic [31:0] act, logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s: actual=%h expected=%h", cur_req, what, act, exp);
      end
   endtask

   task automatic compare();
      logic [31:0] rd;
      logic [8:0]  dom;
      for (int k = 0; k < ND; k++) dom[k] = seen(k);
      rd = '0;
      if (bus_sel && bus_addr == OFF) begin
         rd = m_rsv;
         for (int k = 0; k < ND; k++) rd[POS[k]] = dom[k];
      end
      check("dom_off", {23'b0, dom_off_o}, {23'b0, dom});
      check("rdata", bus_rdata, rd);
      check("err_pulse", {31'b0, err_pulse_o}, {31'b0, any_err()});
      check("err_sticky", {31'b0, err_sticky_o}, {31'b0, m_sticky});
   endtask

   task automatic cyc(bit sel, bit wr, bit priv, logic [11:0] addr, logic [31:0] wd,
                      bit wake, logic [35:0] flip, bit clr);
      bit errnow;
      bus_sel = sel; bus_wr = wr; bus_priv = priv; bus_addr = addr;
      bus_wdata = wd; wake_i = wake; flip_i = flip; err_clr_i = clr;
      @(posedge clk);
      errnow = any_err();
      m_sticky = errnow | (m_sticky & ~clr);
      if (wake) begin
         for (int k = 0; k < ND; k++) begin m_val[k] = 0; m_msk[k] = '0; end
         m_rsv = '0;
      end else if (sel && wr && priv && addr == OFF) begin
         for (int k = 0; k < ND; k++) begin m_val[k] = wd[POS[k]]; m_msk[k] = '0; end
         m_rsv = wd & ~func_m;
      end else begin
         for (int k = 0; k < ND; k++) if (m_msk[k] != '0) begin
            m_val[k] = seen(k); m_msk[k] = '0;
         end
      end
      for (int k = 0; k < ND; k++) m_msk[k] ^= flip[k*KW +: KW];
      @(negedge clk);
      compare();
   endtask

   task automatic wr_p(logic [31:0] d); cyc(1, 1, 1, OFF, d, 0, '0, 0); endtask
   task automatic rd_p(bit priv);      cyc(1, 0, priv, OFF, '0, 0, '0, 0); endtask

   initial begin
      #400000;
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog: actual=running expected=done");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      func_m = '0;
      for (int k = 0; k < ND; k++) begin func_m[POS[k]] = 1'b1; m_val[k] = 0; m_msk[k] = '0; end
      m_rsv = '0; m_sticky = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      cur_req = "R1"; bus_sel = 1; bus_addr = OFF; compare();
      rd_p(1);

      cur_req = "R2"; wr_p(32'h0000_0935); rd_p(1);
      wr_p(32'h0000_097F); rd_p(1);
      wr_p(32'h0000_0042); rd_p(1);

      cur_req = "R3";
      cyc(1, 1, 0, OFF, 32'hFFFF_FFFF, 0, '0, 0);
      rd_p(0); rd_p(1);

      cur_req = "R4";
      cyc(1, 1, 1, 12'h040, 32'hFFFF_FFFF, 0, '0, 0);
      cyc(0, 1, 1, OFF, 32'hFFFF_FFFF, 0, '0, 0);
      cyc(1, 0, 1, 12'h038, '0, 0, '0, 0);
      rd_p(1);

      cur_req = "R5"; wr_p(32'hFFFF_F680); rd_p(0);
      wr_p(32'hA5A5_A5A5); rd_p(1);

      cur_req = "R6";
      cyc(1, 0, 1, OFF, '0, 1, '0, 0); rd_p(1);
      wr_p(32'h0000_0155);
      cyc(1, 1, 1, OFF, 32'hFFFF_FFFF, 1, '0, 0); rd_p(1);

      cur_req = "R7";
      wr_p(32'h0000_0815);
      for (int i = 0; i < ND*KW; i++) begin
         cur_req = "R7";
         cyc(1, 0, 1, OFF, '0, 0, 36'(1) << i, 0);
         cur_req = "R8";
         rd_p(1);
         cur_req = "R10";
         cyc(1, 0, 1, OFF, '0, 0, '0, 1);
      end

      cur_req = "R10";
      cyc(1, 0, 1, OFF, '0, 0, 36'h0_0000_0010, 0);
      cyc(1, 0, 1, OFF, '0, 0, '0, 1);
      rd_p(1);
      cyc(1, 0, 1, OFF, '0, 0, '0, 1);
      rd_p(1);

      cur_req = "R9";
      wr_p(32'h0000_097F);
      cyc(1, 0, 1, OFF, '0, 0, 36'h0_0000_0030, 0);
      rd_p(1); rd_p(1);
      cyc(1, 0, 1, OFF, '0, 0, 36'h0_0000_0C00, 0);
      rd_p(1); rd_p(1);

      cur_req = "R11";
      cyc(1, 0, 1, OFF, '0, 0, 36'h0_0000_0100, 0);
      wr_p(32'h0000_0006); rd_p(1);
      cyc(1, 0, 1, OFF, '0, 0, '0, 1); rd_p(1);

      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule